// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces a repeated-start condition on an open-drain I2C bus. It drives SCL and SDA only through drive-low enables. It reads both lines back through a two-flop synchronizer, and each phase of the sequence moves on only once the line has reached the level the sequence expects. A reloadable baud down-counter times each phase. The counter restarts from the cycle in which the pin edge is seen, so a slow bus or another device holding a line stretches the phase instead of shortening it.

Software uses a register-style interface. It sets a sequence-enable bit in a 5-bit control field, supplies a 7-bit baud reload, and may write a transmit buffer. The block reports a sticky write-collision flag, a start-detected bit, an interrupt flag and a sticky bus-collision flag. While the sequence runs, the control field and the buffer are locked. When the sequence finishes, the block returns to idle with SDA still held low and SCL released. A byte engine outside this block can then take over the bus.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A control write with bit 1 (sequence enable) set starts the sequence only when the block is idle and `bus_busy` is low. If `bus_busy` is high, the other control bits are still stored, bit 1 stays 0 and the lines are not touched.
- R2: When the sequence starts, SCL is driven low. SDA is released once SCL reads back low. SCL stays low for reload+4 clocks: two synchronizer stages, one load cycle and one baud period.
- R3: If SDA reads low when the first baud period ends, or when SCL is seen to rise, a bus collision is flagged.
- R4: After SCL reads back high, both lines stay high for reload+4 clocks before SDA is driven low.
- R5: SDA is driven low while SCL is high for reload+1 clocks. Then the enable bit clears, `idle_ready` rises, and the block leaves SDA low and SCL released.
- R6: `start_seen` is set when SDA falls while SCL is high on the synchronized lines, which is three clocks after SDA is driven low. `irq` rises only at the end of the final baud period or on a collision.
- R7: A buffer write while the sequence runs sets `wcol` and leaves `tx_q` unchanged. A buffer write while idle loads `tx_q` and leaves `wcol` as it was.
- R8: Control writes are ignored while the sequence runs, so no command can be queued.
- R9: If SCL reads low during the high phase or the SDA-low phase, or if SDA reads low during the high phase, the block flags a bus collision. It then releases both lines, clears the enable bit, returns to idle and raises `irq`. `bcol`, `irq` and `wcol` stay set until their clear inputs are pulsed.
- R10: Each baud period lasts reload+1 clocks from the cycle the counter is loaded, and it ends with a one-cycle timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control field write strobe |
| ctrl_wdata | input | 5 | Control write data, bit 1 = sequence enable |
| ctrl_q | output | 5 | Control field contents |
| bus_busy | input | 1 | Another bus event is in progress |
| baud_reload | input | BAUD_W | Baud counter reload value |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DATA_W | Transmit buffer write data |
| tx_q | output | DATA_W | Transmit buffer contents |
| wcol | output | 1 | Write-collision flag (sticky) |
| wcol_clr | input | 1 | Clears `wcol` |
| start_seen | output | 1 | Start condition detected on the lines |
| irq | output | 1 | Interrupt flag (sticky) |
| irq_clr | input | 1 | Clears `irq` |
| bcol | output | 1 | Bus-collision flag (sticky) |
| bcol_clr | input | 1 | Clears `bcol` |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_low | output | 1 | Drive SCL low |
| sda_low | output | 1 | Drive SDA low |
| idle_ready | output | 1 | Sequencer idle |

## Verification
The bench builds the block with its defaults: a 7-bit reload and a two-stage synchronizer. These make every phase length an exact, predictable count. Reload values of 0, 2, 3, 5, 6 and 8 cover the one-clock baud period, the case where a load coincides with a timeout, and the ordering of `start_seen` before `irq`. Open-drain pull-downs in the bench model another device. They bring both collision paths within reach: SDA held low through the first period, and SCL pulled low in the middle of the high phase.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int unsigned CTRL_W    = 5;
    localparam int unsigned RS_EN_BIT = 1;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SCL_DROP,
        RS_LOW_HOLD,
        RS_SCL_RISE,
        RS_HIGH_HOLD,
        RS_SDA_HOLD
    } rs_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } rs_drive_t;

    // Line drive per phase; SDA stays parked low until SCL reads low.
    function automatic rs_drive_t drive_for(rs_state_e st, logic parked);
        rs_drive_t d;
        d.scl_low = (st == RS_SCL_DROP) || (st == RS_LOW_HOLD);
        d.sda_low = (st == RS_SDA_HOLD) ||
                    (parked && ((st == RS_IDLE) || (st == RS_SCL_DROP)));
        return d;
    endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rs_baud.sv
module rs_baud #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         halt,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         active;

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= reload;
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign tick = active && (cnt == '0);

    p_tick_single_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> !tick);

    p_count_down_r10: assert property (@(posedge clk) disable iff (rst)
        (active && !tick && !load && !halt) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import i2c_rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      scl_s,
    input  logic      sda_s,
    input  logic      tick,
    output logic      load,
    output logic      halt,
    output logic      idle,
    output logic      done_p,
    output logic      coll_p,
    output rs_drive_t drv
);
    rs_state_e st, nxt;
    logic      parked_q, parked_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RS_IDLE;
            parked_q <= 1'b0;
        end else begin
            st       <= nxt;
            parked_q <= parked_d;
        end
    end

    always_comb begin
        nxt      = st;
        parked_d = parked_q;
        load     = 1'b0;
        done_p   = 1'b0;
        coll_p   = 1'b0;
        unique case (st)
            RS_IDLE: if (start) nxt = RS_SCL_DROP;
            RS_SCL_DROP: if (!scl_s) begin
                load     = 1'b1;
                parked_d = 1'b0;
                nxt      = RS_LOW_HOLD;
            end
            RS_LOW_HOLD: if (tick) begin
                if (sda_s) nxt    = RS_SCL_RISE;
                else       coll_p = 1'b1;
            end
            RS_SCL_RISE: if (scl_s) begin
                if (sda_s) begin
                    load = 1'b1;
                    nxt  = RS_HIGH_HOLD;
                end else begin
                    coll_p = 1'b1;
                end
            end
            RS_HIGH_HOLD: begin
                if (!scl_s || !sda_s) begin
                    coll_p = 1'b1;
                end else if (tick) begin
                    load = 1'b1;
                    nxt  = RS_SDA_HOLD;
                end
            end
            RS_SDA_HOLD: begin
                if (!scl_s) begin
                    coll_p = 1'b1;
                end else if (tick) begin
                    done_p   = 1'b1;
                    parked_d = 1'b1;
                    nxt      = RS_IDLE;
                end
            end
            default: nxt = RS_IDLE;
        endcase
        if (coll_p) begin
            nxt      = RS_IDLE;
            parked_d = 1'b0;
        end
    end

    assign halt = coll_p;
    assign idle = (st == RS_IDLE);
    assign drv  = drive_for(st, parked_q);

    p_low_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (st == RS_LOW_HOLD) |-> !scl_s);

    p_park_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        done_p |=> (idle && drv.sda_low && !drv.scl_low));
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
    import i2c_rs_pkg::*;
#(
    parameter int BAUD_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              bus_busy,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic [DATA_W-1:0] tx_q,
    output logic              wcol,
    input  logic              wcol_clr,
    output logic              start_seen,
    output logic              irq,
    input  logic              irq_clr,
    output logic              bcol,
    input  logic              bcol_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic              idle_ready
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s, sda_prev;
    logic       tick, load, halt, idle, done_p, coll_p, start;
    rs_drive_t  drv;

    rs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    rs_baud #(.W(BAUD_W)) u_baud (
        .clk(clk), .rst(rst), .halt(halt), .load(load),
        .reload(baud_reload), .tick(tick)
    );

    assign start = ctrl_wr && ctrl_wdata[RS_EN_BIT] && idle && !bus_busy;

    rs_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .scl_s(scl_s), .sda_s(sda_s),
        .tick(tick), .load(load), .halt(halt), .idle(idle),
        .done_p(done_p), .coll_p(coll_p), .drv(drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            tx_q       <= '0;
            wcol       <= 1'b0;
            irq        <= 1'b0;
            bcol       <= 1'b0;
            start_seen <= 1'b0;
            sda_prev   <= 1'b1;
        end else begin
            sda_prev <= sda_s;
            if (done_p || coll_p) begin
                ctrl_q[RS_EN_BIT] <= 1'b0;
            end else if (ctrl_wr && idle) begin
                ctrl_q            <= ctrl_wdata;
                ctrl_q[RS_EN_BIT] <= ctrl_wdata[RS_EN_BIT] && !bus_busy;
            end
            if (tx_wr && idle)       tx_q <= tx_wdata;
            if (tx_wr && !idle)      wcol <= 1'b1;
            else if (wcol_clr)       wcol <= 1'b0;
            if (done_p || coll_p)    irq  <= 1'b1;
            else if (irq_clr)        irq  <= 1'b0;
            if (coll_p)              bcol <= 1'b1;
            else if (bcol_clr)       bcol <= 1'b0;
            if (start)                                start_seen <= 1'b0;
            else if (sda_prev && !sda_s && scl_s)     start_seen <= 1'b1;
        end
    end

    assign scl_low    = drv.scl_low;
    assign sda_low    = drv.sda_low;
    assign idle_ready = idle;

    p_busy_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (idle && bus_busy && ctrl_wr) |=> (idle_ready && !ctrl_q[RS_EN_BIT]));

    p_ctrl_locked_r8: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable({ctrl_q[4:2], ctrl_q[0]}));

    p_buf_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !idle) |=> (wcol && $stable(tx_q)));

    p_coll_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(bcol) |-> (!scl_low && !sda_low && idle_ready));

    p_irq_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(done_p || coll_p));
endmodule

// File: tb/test_i2c_rstart_seq.sv
module test_i2c_rstart_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [4:0] ctrl_q;
    logic       bus_busy = 1'b0;
    logic [6:0] baud_reload = '0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] tx_q;
    logic       wcol, wcol_clr = 1'b0;
    logic       start_seen, irq, bcol;
    logic       irq_clr = 1'b0, bcol_clr = 1'b0;
    logic       scl_in, sda_in, scl_low, sda_low, idle_ready;
    logic       ext_scl = 1'b0, ext_sda = 1'b0;
    int         checks = 0, failures = 0, cyc = 0;

    always #2 clk = ~clk;

    assign scl_in = !scl_low && !ext_scl;
    assign sda_in = !sda_low && !ext_sda;

    i2c_rstart_seq i_i2c_rstart_seq (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .bus_busy(bus_busy), .baud_reload(baud_reload),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_q(tx_q), .wcol(wcol),
        .wcol_clr(wcol_clr), .start_seen(start_seen), .irq(irq),
        .irq_clr(irq_clr), .bcol(bcol), .bcol_clr(bcol_clr),
        .scl_in(scl_in), .sda_in(sda_in), .scl_low(scl_low),
        .sda_low(sda_low), .idle_ready(idle_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            report();
        end
    end

    task automatic pulse_clear(input int which);
        @(negedge clk);
        irq_clr  = (which == 0);
        bcol_clr = (which == 1);
        wcol_clr = (which == 2);
        @(negedge clk);
        irq_clr = 1'b0; bcol_clr = 1'b0; wcol_clr = 1'b0;
    endtask

    task automatic issue(input logic [4:0] data, input int r);
        @(negedge clk);
        baud_reload = 7'(r);
        ctrl_wdata  = data;
        ctrl_wr     = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wait_irq(input int limit, input string tag);
        int g = 0;
        while (!irq && g < limit) begin
            @(negedge clk);
            g++;
        end
        chk(irq, {tag, " irq raised"}, irq, 1);
    endtask

    task automatic t_reset();
        chk(scl_in && sda_in, "R5 lines released after reset", {scl_in, sda_in}, 3);
        chk(idle_ready && !irq && !bcol && !wcol && !start_seen && ctrl_q == 0,
            "R1 reset state", {idle_ready, irq, bcol, wcol, start_seen}, 16);
    endtask

    task automatic t_normal(input int r);
        int lowc = 0, hih = 0, holdc = 0, g = 0;
        bit early = 0;
        issue(5'b00010, r);
        while (!irq && g < 2000) begin
            if (!scl_in)     lowc++;
            else if (sda_in) hih++;
            else             holdc++;
            if (start_seen) early = 1;
            @(negedge clk);
            g++;
        end
        chk(irq, "R6 irq after sequence", irq, 1);
        chk(lowc == r + 4, "R2 SCL low length", lowc, r + 4);
        chk(hih == r + 4, "R4 both-high length", hih, r + 4);
        chk(holdc == r + 1, "R5 R10 SDA-low hold length", holdc, r + 1);
        if (r >= 3) chk(early, "R6 start_seen before irq", early, 1);
        repeat (3) @(negedge clk);
        chk(start_seen, "R6 start_seen set", start_seen, 1);
        chk(!ctrl_q[1] && idle_ready, "R5 enable cleared, idle", {ctrl_q[1], idle_ready}, 1);
        chk(!sda_in && scl_in, "R5 SDA held low, SCL high", {sda_in, scl_in}, 1);
        chk(!bcol, "R3 no collision on clean bus", bcol, 0);
        pulse_clear(0);
        chk(!irq, "R9 irq cleared by software", irq, 0);
    endtask

    task automatic t_busy();
        bit stayed = 1;
        bus_busy = 1'b1;
        issue(5'b00110, 4);
        for (int i = 0; i < 10; i++) begin
            if (!scl_in || !idle_ready) stayed = 0;
            @(negedge clk);
        end
        chk(stayed, "R1 request ignored while busy", stayed, 1);
        chk(ctrl_q == 5'b00100, "R1 enable bit not stored", ctrl_q, 5'b00100);
        bus_busy = 1'b0;
    endtask

    task automatic t_lockout();
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = 8'hA5;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_q == 8'hA5 && !wcol, "R7 idle buffer write", tx_q, 8'hA5);
        issue(5'b10011, 6);
        repeat (4) @(negedge clk);
        tx_wr = 1'b1; tx_wdata = 8'h3C;
        @(negedge clk);
        tx_wr = 1'b0;
        ctrl_wr = 1'b1; ctrl_wdata = 5'b01100;
        @(negedge clk);
        ctrl_wr = 1'b0;
        chk(wcol, "R7 wcol set on busy write", wcol, 1);
        chk(tx_q == 8'hA5, "R7 buffer unchanged", tx_q, 8'hA5);
        chk(ctrl_q == 5'b10011, "R8 control write ignored", ctrl_q, 5'b10011);
        wait_irq(200, "R8");
        chk(ctrl_q == 5'b10001, "R8 only enable bit cleared", ctrl_q, 5'b10001);
        chk(tx_q == 8'hA5, "R7 buffer unchanged at end", tx_q, 8'hA5);
        pulse_clear(2);
        chk(!wcol, "R9 wcol cleared", wcol, 0);
        pulse_clear(0);
    endtask

    task automatic t_coll_sda();
        ext_sda = 1'b1;
        issue(5'b00010, 3);
        wait_irq(200, "R3");
        @(negedge clk);
        chk(bcol, "R3 collision on SDA low", bcol, 1);
        chk(!scl_low && !sda_low && idle_ready && !ctrl_q[1],
            "R9 lines released after collision", {scl_low, sda_low, idle_ready}, 1);
        ext_sda = 1'b0;
        repeat (5) @(negedge clk);
        chk(bcol, "R9 bcol sticky", bcol, 1);
        pulse_clear(1);
        chk(!bcol, "R9 bcol cleared", bcol, 0);
        pulse_clear(0);
    endtask

    task automatic t_coll_scl();
        int g = 0;
        issue(5'b00010, 8);
        while (scl_in && g < 100) begin @(negedge clk); g++; end
        while (!scl_in && g < 200) begin @(negedge clk); g++; end
        repeat (5) @(negedge clk);
        ext_scl = 1'b1;
        wait_irq(40, "R9");
        @(negedge clk);
        chk(bcol, "R9 collision on SCL low in high phase", bcol, 1);
        chk(!scl_low && !sda_low && idle_ready && !ctrl_q[1],
            "R9 released and idle", {scl_low, sda_low, idle_ready}, 1);
        ext_scl = 1'b0;
        pulse_clear(1);
        pulse_clear(0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal(0);
        t_normal(2);
        t_normal(5);
        t_busy();
        t_lockout();
        t_coll_sda();
        t_coll_scl();
        t_normal(3);
        report();
    end
endmodule